// File: doc/BRIEF.md
# Card Presence and Wake-Up Detector

This block decides whether a removable card sits in its slot and reports when that changes. Presence comes from one of two sources. The first is the raw card-detect pin, which is resynchronised into the core clock. The second is a software test level, used when a test-select input is high. The block watches the selected presence signal for edges. An insertion produces a single-cycle insertion pulse. A removal produces a single-cycle removal pulse and, in the same cycle, a power-clear pulse that tells the supply logic to drop card power for hot removal.

Three per-event enables (removal, insertion, card interrupt) decide which events may raise a wake request. The wake request is a level. It stays high until the system acknowledges it. The block comes out of reset assuming an empty slot, so a card that is already present is reported as an insertion.

Top module: `card_wake_unit`

## Requirements
- R1: With `testSel` = 0 the presence source is `cdPin` (1 = card present). It passes a two-flop synchronizer, so a pin change driven before clock edge 0 appears on `cardPresent` after edge 2.
- R2: With `testSel` = 1 the presence source is `testLevel` (1 = card inserted). It appears on `cardPresent` after the next clock edge.
- R3: A low-to-high change of the selected presence gives `insertPulse` = 1 for exactly one cycle, in the same cycle `cardPresent` first reads 1.
- R4: A high-to-low change of the selected presence gives `removePulse` = 1 and `powerClear` = 1 for exactly one cycle, in the same cycle `cardPresent` first reads 0.
- R5: A removal sets `wakeReq` only when `enRemoval` = 1.
- R6: An insertion sets `wakeReq` only when `enInsert` = 1.
- R7: A rising edge of `cardIrq` sets `wakeReq` on the next clock edge, only when `enIrq` = 1. A held-high `cardIrq` does not set it again.
- R8: `wakeReq` stays at 1 until a cycle with `wakeAck` = 1 clears it. If an enabled event and `wakeAck` occur in the same cycle, `wakeReq` is set.
- R9: While `rstN` = 0, all outputs are 0 and the slot is taken to be empty.
- R10: While `testSel` = 1, changes on `cdPin` have no effect on `cardPresent`, `insertPulse` or `removePulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cdPin | input | 1 | Raw card-detect pin, 1 = card present |
| testSel | input | 1 | 1 selects the software test level as presence source |
| testLevel | input | 1 | Software presence level, 1 = card inserted |
| cardIrq | input | 1 | Card interrupt line, active high |
| enRemoval | input | 1 | Allow wake-up on removal |
| enInsert | input | 1 | Allow wake-up on insertion |
| enIrq | input | 1 | Allow wake-up on card interrupt |
| wakeAck | input | 1 | Clears the wake request |
| cardPresent | output | 1 | Registered presence state |
| insertPulse | output | 1 | One-cycle insertion event |
| removePulse | output | 1 | One-cycle removal event |
| powerClear | output | 1 | One-cycle request to drop card power on removal |
| wakeReq | output | 1 | Held wake-up request |

## Verification
The hardest case to reach from the ports is a wake event that arrives in the same cycle as an acknowledge. The pin path makes that cycle hard to hit, because its latency depends on the synchronizer. The bench therefore drives presence through the test level, which lands one edge after the drive. This lets a table row place an insertion and `wakeAck` in the same cycle. Switching the source from test level back to a pin that has already settled creates a removal with no pin activity at all. Pin latency and pin immunity under test mode are then checked by directed cycle counting.

// File: rtl/cdw_pkg.sv
package cdw_pkg;
  typedef struct packed {
    logic insEdge;
    logic remEdge;
    logic setWake;
    logic clrWake;
  } cdwStrobe_t;
endpackage

// File: rtl/cdw_datapath.sv
module cdw_datapath
  import cdw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cdPin,
  input  logic       testSel,
  input  logic       testLevel,
  input  logic       cardIrq,
  input  cdwStrobe_t strb,
  output logic       selPres,
  output logic       presQ,
  output logic       irqQ,
  output logic       insQ,
  output logic       remQ,
  output logic       pwrQ,
  output logic       wakeQ
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '0;
        else       syncChain <= cdPin;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[LAST-1:0], cdPin};
    end
  endgenerate

  assign selPres = testSel ? testLevel : syncChain[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presQ <= 1'b0;
      irqQ  <= 1'b0;
      insQ  <= 1'b0;
      remQ  <= 1'b0;
      pwrQ  <= 1'b0;
      wakeQ <= 1'b0;
    end else begin
      presQ <= selPres;
      irqQ  <= cardIrq;
      insQ  <= strb.insEdge;
      remQ  <= strb.remEdge;
      pwrQ  <= strb.remEdge;
      if (strb.setWake)      wakeQ <= 1'b1;
      else if (strb.clrWake) wakeQ <= 1'b0;
    end
  end

  a_r3_ins_one_wide: assert property (@(posedge clk) disable iff (!rstN)
    insQ |=> !insQ);
  a_r3_ins_with_present: assert property (@(posedge clk) disable iff (!rstN)
    insQ |-> presQ);
  a_r4_rem_one_wide: assert property (@(posedge clk) disable iff (!rstN)
    remQ |=> !remQ);
  a_r4_pwr_with_remove: assert property (@(posedge clk) disable iff (!rstN)
    pwrQ |-> (remQ && !presQ));
  a_r2_test_level_follows: assert property (@(posedge clk) disable iff (!rstN)
    testSel |=> (presQ == $past(testLevel)));
  a_r8_wake_held: assert property (@(posedge clk) disable iff (!rstN)
    (wakeQ && !strb.clrWake) |=> wakeQ);
endmodule

// File: rtl/cdw_control.sv
module cdw_control
  import cdw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selPres,
  input  logic       presQ,
  input  logic       cardIrq,
  input  logic       irqQ,
  input  logic       enRemoval,
  input  logic       enInsert,
  input  logic       enIrq,
  input  logic       wakeAck,
  input  logic       wakeQ,
  output cdwStrobe_t strb
);
  logic irqEdge;

  always_comb begin
    irqEdge      = cardIrq & ~irqQ;
    strb.insEdge = selPres & ~presQ;
    strb.remEdge = ~selPres & presQ;
    strb.setWake = (strb.insEdge & enInsert) |
                   (strb.remEdge & enRemoval) |
                   (irqEdge & enIrq);
    strb.clrWake = wakeAck;
  end

  a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.insEdge && strb.remEdge));
  a_r5_no_wake_without_enable: assert property (@(posedge clk) disable iff (!rstN)
    (!wakeQ && !(enInsert && strb.insEdge) && !(enRemoval && strb.remEdge)
     && !(enIrq && cardIrq && !irqQ)) |=> !wakeQ);
  a_r8_ack_without_event_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wakeAck && !strb.setWake) |=> !wakeQ);
endmodule

// File: rtl/card_wake_unit.sv
module card_wake_unit
  import cdw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cdPin,
  input  logic testSel,
  input  logic testLevel,
  input  logic cardIrq,
  input  logic enRemoval,
  input  logic enInsert,
  input  logic enIrq,
  input  logic wakeAck,
  output logic cardPresent,
  output logic insertPulse,
  output logic removePulse,
  output logic powerClear,
  output logic wakeReq
);
  cdwStrobe_t strb;
  logic selPres, presQ, irqQ;

  cdw_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .cdPin(cdPin), .testSel(testSel),
    .testLevel(testLevel), .cardIrq(cardIrq), .strb(strb),
    .selPres(selPres), .presQ(presQ), .irqQ(irqQ),
    .insQ(insertPulse), .remQ(removePulse), .pwrQ(powerClear),
    .wakeQ(wakeReq)
  );

  cdw_control u_ctl (
    .clk(clk), .rstN(rstN), .selPres(selPres), .presQ(presQ),
    .cardIrq(cardIrq), .irqQ(irqQ), .enRemoval(enRemoval),
    .enInsert(enInsert), .enIrq(enIrq), .wakeAck(wakeAck),
    .wakeQ(wakeReq), .strb(strb)
  );

  assign cardPresent = presQ;

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rstN |-> !(cardPresent || insertPulse || removePulse || powerClear || wakeReq));
endmodule

// File: tb/tb_card_wake_unit.sv
module tb_card_wake_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cdPin = 0, testSel = 0, testLevel = 0, cardIrq = 0;
  logic enRemoval = 0, enInsert = 0, enIrq = 0, wakeAck = 0;
  logic cardPresent, insertPulse, removePulse, powerClear, wakeReq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  card_wake_unit dut (
    .clk(clk), .rstN(rstN), .cdPin(cdPin), .testSel(testSel),
    .testLevel(testLevel), .cardIrq(cardIrq), .enRemoval(enRemoval),
    .enInsert(enInsert), .enIrq(enIrq), .wakeAck(wakeAck),
    .cardPresent(cardPresent), .insertPulse(insertPulse),
    .removePulse(removePulse), .powerClear(powerClear), .wakeReq(wakeReq)
  );

  // {tsel,tlvl,irq,enR,enI,enQ,ack | pres,ins,rem,wake}
  localparam int NV = 15;
  localparam logic [10:0] VEC [NV] = '{
    11'b1100100_1101,  // R3 R6 insert, wake enabled
    11'b1100101_1000,  // R8 ack clears
    11'b1000000_0010,  // R4 R5 removal, wake disabled
    11'b1000000_0000,  // R4 pulse one wide
    11'b1100000_1100,  // R6 insert, disabled
    11'b1001000_0011,  // R5 removal wakes
    11'b1001000_0001,  // R8 level held
    11'b1000001_0000,  // R8 ack
    11'b1010000_0000,  // R7 irq, disabled
    11'b1000000_0000,
    11'b1010010_0001,  // R7 irq wakes
    11'b1010011_0000,  // R7 held irq, no new set
    11'b1000000_0000,
    11'b1100101_1101,  // R8 set wins over ack
    11'b0100100_0011   // R1 switch to settled pin -> removal
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input logic p, input logic i,
                          input logic r, input logic w);
    check(req, "cardPresent", cardPresent, p);
    check(req, "insertPulse", insertPulse, i);
    check(req, "removePulse", removePulse, r);
    check("R4", "powerClear", powerClear, r);
    check(req, "wakeReq", wakeReq, w);
  endtask

  initial begin
    #1600000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    checkAll("R9", 0, 0, 0, 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < NV; k++) begin
      {testSel, testLevel, cardIrq, enRemoval, enInsert, enIrq, wakeAck} = VEC[k][10:4];
      @(negedge clk);
      checkAll($sformatf("R2/row%0d", k), VEC[k][3], VEC[k][2], VEC[k][1], VEC[k][0]);
    end
    // clear wake, disable events
    {enRemoval, enInsert, enIrq, wakeAck} = 4'b0001;
    @(negedge clk);
    wakeAck = 0;
    // R1 pin latency through the synchronizer
    cdPin = 1;
    @(negedge clk); check("R1", "present after 1 edge", cardPresent, 0);
    @(negedge clk); check("R1", "present after 2 edges", cardPresent, 0);
    @(negedge clk); check("R1", "present after 3 edges", cardPresent, 1);
    check("R3", "insert on pin", insertPulse, 1);
    @(negedge clk); check("R3", "insert one wide", insertPulse, 0);
    // R10 pin ignored in test mode
    testSel = 1; testLevel = 1;
    @(negedge clk);
    cdPin = 0;
    begin
      int seen = 0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (removePulse || insertPulse || !cardPresent) seen++;
      end
      check("R10", "pin activity under test mode", seen != 0, 1'b0);
    end
    // R9 reset clears a pending wake
    enIrq = 1; cardIrq = 1;
    @(negedge clk); check("R7", "irq wake", wakeReq, 1);
    rstN = 0;
    #1;
    checkAll("R9", 0, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule